// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder

This block turns the sampled control pins of a two-bank synchronous graphics DRAM into one-hot command pulses. Each clock it looks at chip select, the three strobes (row, column, write enable), the special-function input, the current and previous clock-enable samples, the bank select and address bit 8. It also tracks whether each bank holds an open row, and lets a command through only in a bank state that permits it.

A command that the current state forbids raises a one-cycle illegal flag instead of a command pulse, and leaves the bank state untouched. The special-function input splits several base opcodes into variants: an activate that also turns on masked writes, a block write, and a special mode-register load.

A small burst timer follows the most recent read or write. It lets burst stop be checked, it freezes while the internal clock is suspended, and it closes the row when a burst with auto precharge ends. All outputs are registered. A command sampled at one rising edge appears on the outputs right after that edge, and the bank state it causes appears at the same time.

Top module: `gdram_cmd_decoder`

## Requirements
- R1: After reset both banks read idle (`bank_active_o` = 0), `cmd_o` is all zero and `illegal_o` is low.
- R2: With the previous clock-enable sample high, chip select high gives a deselect pulse (`cmd_o` bit 1) and changes no bank state. Chip select low with all three strobes high gives a no-operation pulse (bit 0).
- R3: Strobes row=L, column=H, write=H activate the bank on `bank_i`, which becomes active. Special-function low gives bit 2 and high gives bit 3 (masked writes enabled). Activating a bank that is already active is illegal.
- R4: Strobes row=L, column=H, write=H→L with special-function low precharge. Address bit 8 low closes only the `bank_i` bank (bit 4) and high closes both (bit 5). Precharge is legal in any state. The same opcode with special-function high is illegal.
- R5: Row=H, column=L, write=L is a write and write=H is a read, allowed only when the selected bank is active. Write: bit 6, with auto precharge bit 7. Block write (special-function high): bit 8, with auto precharge bit 9. Read: bit 10, with auto precharge bit 11. A read with special-function high is illegal.
- R6: A read or write with auto precharge closes its bank after BURST_LEN clock edges (one edge for block write). Only edges with the previous clock-enable sample high are counted.
- R7: All strobes low loads the mode register (special-function low, bit 12) only when both banks are idle. With special-function high it loads the special mode register (bit 13) in any state. Row=L, column=L, write=H with special-function low is auto refresh (bit 14), allowed only when both banks are idle.
- R8: Row=H, column=H, write=L with special-function low is burst stop (bit 16). It is legal only while a burst runs and ends that burst. If the burst had auto precharge pending, its bank closes at the same edge.
- R9: Previous clock-enable high and current low: if any bank is active the result is clock suspend (bit 17). Otherwise deselect or no-operation gives power-down (bit 18), the refresh opcode gives self-refresh entry (bit 15), and any other opcode is illegal.
- R10: While the previous clock-enable sample is low, no pulse and no illegal flag is produced, and bank state and burst progress are held.
- R11: An illegal command pulses `illegal_o` for one cycle with no `cmd_o` bit set and no bank state change. Undefined special-function variants (refresh or burst-stop opcode with special-function high) are illegal.
- R12: At most one of `cmd_o` and `illegal_o` is set in any cycle, one clock after the inputs are sampled.
- R13: A read or write issued while a burst with auto precharge pending is still running is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| dsf_i | input | 1 | Special-function select |
| cke_prev_i | input | 1 | Clock enable sampled one cycle earlier |
| cke_i | input | 1 | Clock enable, current sample |
| bank_i | input | BANK_W | Bank select |
| a8_i | input | 1 | Address bit 8 (auto precharge / all banks) |
| cmd_o | output | NUM_CMD | One-hot command pulse |
| illegal_o | output | 1 | Illegal-command pulse |
| bank_active_o | output | NUM_BANKS | Per-bank open-row state |

## Verification
The hardest state to reach from the ports is an auto-precharge burst whose count is frozen partway by clock suspend. The row must stay open across the suspended cycles and close only when the remaining counted edges have passed. The stimulus opens a bank and issues a read with auto precharge. It then drops clock enable, which gives a suspend pulse, holds both samples low for several vectors that include an activate the design must ignore, and restores clock enable. The expected close edge is counted by hand. A second burst with auto precharge is interrupted by a read, which must be refused, and a third is cut short by burst stop, which must close its row at once.

// File: rtl/gdram_cmd_pkg.sv
package gdram_cmd_pkg;
  localparam int NUM_CMD = 19;

  // enum value = bit position in cmd_o
  typedef enum logic [4:0] {
    CMD_NOP    = 5'd0,
    CMD_DESEL  = 5'd1,
    CMD_ACT    = 5'd2,
    CMD_ACT_MW = 5'd3,
    CMD_PRE    = 5'd4,
    CMD_PREALL = 5'd5,
    CMD_WR     = 5'd6,
    CMD_WRA    = 5'd7,
    CMD_BW     = 5'd8,
    CMD_BWA    = 5'd9,
    CMD_RD     = 5'd10,
    CMD_RDA    = 5'd11,
    CMD_MRS    = 5'd12,
    CMD_SMRS   = 5'd13,
    CMD_REF    = 5'd14,
    CMD_SREF   = 5'd15,
    CMD_BST    = 5'd16,
    CMD_CSUSP  = 5'd17,
    CMD_PDN    = 5'd18
  } cmd_e;

  // strobe opcodes {ras_n, cas_n, we_n}
  localparam logic [2:0] OP_NOP = 3'b111;
  localparam logic [2:0] OP_ACT = 3'b011;
  localparam logic [2:0] OP_PRE = 3'b010;
  localparam logic [2:0] OP_WR  = 3'b100;
  localparam logic [2:0] OP_RD  = 3'b101;
  localparam logic [2:0] OP_MRS = 3'b000;
  localparam logic [2:0] OP_REF = 3'b001;
  localparam logic [2:0] OP_BST = 3'b110;
endpackage

// File: rtl/gdram_cmd_classify.sv
module gdram_cmd_classify
  import gdram_cmd_pkg::*;
(
  input  logic       cs_ni,
  input  logic [2:0] op_i,
  input  logic       dsf_i,
  input  logic       cke_prev_i,
  input  logic       cke_i,
  input  logic       a8_i,
  input  logic       sel_active_i,
  input  logic       any_active_i,
  input  logic       burst_busy_i,
  input  logic       ap_busy_i,
  output logic       hit_o,
  output logic       illegal_o,
  output cmd_e       cmd_o
);
  always_comb begin
    hit_o     = 1'b0;
    illegal_o = 1'b0;
    cmd_o     = CMD_NOP;
    if (cke_prev_i) begin
      hit_o = 1'b1;
      if (!cke_i) begin
        if (any_active_i)                      cmd_o = CMD_CSUSP;
        else if (cs_ni || op_i == OP_NOP)      cmd_o = CMD_PDN;
        else if (op_i == OP_REF && !dsf_i)     cmd_o = CMD_SREF;
        else                                   illegal_o = 1'b1;
      end else if (cs_ni) begin
        cmd_o = CMD_DESEL;
      end else begin
        unique case (op_i)
          OP_NOP: cmd_o = CMD_NOP;
          OP_ACT: begin
            if (sel_active_i) illegal_o = 1'b1;
            else              cmd_o = dsf_i ? CMD_ACT_MW : CMD_ACT;
          end
          OP_PRE: begin
            if (dsf_i) illegal_o = 1'b1;
            else       cmd_o = a8_i ? CMD_PREALL : CMD_PRE;
          end
          OP_WR: begin
            if (!sel_active_i || ap_busy_i) illegal_o = 1'b1;
            else if (dsf_i) cmd_o = a8_i ? CMD_BWA : CMD_BW;
            else            cmd_o = a8_i ? CMD_WRA : CMD_WR;
          end
          OP_RD: begin
            if (dsf_i || !sel_active_i || ap_busy_i) illegal_o = 1'b1;
            else cmd_o = a8_i ? CMD_RDA : CMD_RD;
          end
          OP_MRS: begin
            if (dsf_i)             cmd_o = CMD_SMRS;
            else if (any_active_i) illegal_o = 1'b1;
            else                   cmd_o = CMD_MRS;
          end
          OP_REF: begin
            if (dsf_i || any_active_i) illegal_o = 1'b1;
            else                       cmd_o = CMD_REF;
          end
          OP_BST: begin
            if (dsf_i || !burst_busy_i) illegal_o = 1'b1;
            else                        cmd_o = CMD_BST;
          end
          default: illegal_o = 1'b1;
        endcase
      end
      if (illegal_o) hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/gdram_burst_timer.sv
module gdram_burst_timer #(
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 1,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              ap_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              kill_i,
  input  logic              bst_i,
  output logic              busy_o,
  output logic              ap_pend_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              close_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;
  logic              last_edge;

  assign busy_o    = (cnt_q != '0);
  assign ap_pend_o = busy_o && ap_q;
  assign bank_o    = bank_q;
  assign last_edge = adv_i && (cnt_q == CNT_W'(1)) && !start_i && !kill_i;
  assign close_o   = ap_pend_o && (last_edge || bst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start_i) begin
      cnt_q  <= single_i ? CNT_W'(1) : CNT_W'(BURST_LEN);
      ap_q   <= ap_i;
      bank_q <= bank_i;
    end else if (kill_i || bst_i) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (adv_i && busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) ap_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gdram_bank_state.sv
module gdram_bank_state #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] close_i,
  output logic [NUM_BANKS-1:0] active_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         act_q <= 1'b0;
      else if (open_i[b])  act_q <= 1'b1;
      else if (close_i[b]) act_q <= 1'b0;
    end
    assign active_o[b] = act_q;
  end
endmodule

// File: rtl/gdram_cmd_decoder.sv
module gdram_cmd_decoder
  import gdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 dsf_i,
  input  logic                 cke_prev_i,
  input  logic                 cke_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a8_i,
  output logic [NUM_CMD-1:0]   cmd_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] bank_active_o
);
  logic [NUM_BANKS-1:0] active;
  logic                 hit, ill;
  cmd_e                 cmd;
  logic                 burst_busy, ap_pend, tmr_close;
  logic [BANK_W-1:0]    burst_bank;
  logic                 sel_active;
  logic [NUM_BANKS-1:0] open_vec, close_vec;
  logic                 is_act, is_pre, is_preall, is_bst;
  logic                 is_xfer, is_single, is_ap, kill;
  logic [NUM_CMD-1:0]   cmd_vec;

  assign sel_active = active[bank_i];

  gdram_cmd_classify u_cls (
    .cs_ni        (cs_ni),
    .op_i         ({ras_ni, cas_ni, we_ni}),
    .dsf_i        (dsf_i),
    .cke_prev_i   (cke_prev_i),
    .cke_i        (cke_i),
    .a8_i         (a8_i),
    .sel_active_i (sel_active),
    .any_active_i (|active),
    .burst_busy_i (burst_busy),
    .ap_busy_i    (ap_pend),
    .hit_o        (hit),
    .illegal_o    (ill),
    .cmd_o        (cmd)
  );

  always_comb begin
    is_act    = hit && (cmd == CMD_ACT || cmd == CMD_ACT_MW);
    is_pre    = hit && (cmd == CMD_PRE);
    is_preall = hit && (cmd == CMD_PREALL);
    is_bst    = hit && (cmd == CMD_BST);
    is_single = hit && (cmd == CMD_BW || cmd == CMD_BWA);
    is_ap     = hit && (cmd == CMD_WRA || cmd == CMD_BWA || cmd == CMD_RDA);
    is_xfer   = is_single || is_ap || (hit && (cmd == CMD_WR || cmd == CMD_RD));
    kill      = is_preall || (is_pre && burst_busy && bank_i == burst_bank);
  end

  gdram_burst_timer #(.BURST_LEN(BURST_LEN), .BANK_W(BANK_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (cke_prev_i),
    .start_i   (is_xfer),
    .single_i  (is_single),
    .ap_i      (is_ap),
    .bank_i    (bank_i),
    .kill_i    (kill),
    .bst_i     (is_bst),
    .busy_o    (burst_busy),
    .ap_pend_o (ap_pend),
    .bank_o    (burst_bank),
    .close_o   (tmr_close)
  );

  always_comb begin
    open_vec  = '0;
    close_vec = '0;
    if (is_act) open_vec[bank_i] = 1'b1;
    if (is_pre) close_vec[bank_i] = 1'b1;
    if (is_preall) close_vec = '1;
    if (tmr_close) close_vec[burst_bank] = 1'b1;
  end

  gdram_bank_state #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open_vec),
    .close_i  (close_vec),
    .active_o (active)
  );

  always_comb begin
    cmd_vec      = '0;
    cmd_vec[cmd] = hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      cmd_o     <= cmd_vec;
      illegal_o <= ill;
    end
  end

  assign bank_active_o = active;
endmodule

// File: rtl/gdram_cmd_chk.sv
module gdram_cmd_chk
  import gdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_prev_i,
  input logic [NUM_CMD-1:0]   cmd_o,
  input logic                 illegal_o,
  input logic [NUM_BANKS-1:0] bank_active_o
);
  // R12
  onehot_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_o, illegal_o}));

  // R11
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> bank_active_o == $past(bank_active_o));

  // R10
  frozen_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_prev_i |=> (cmd_o == '0 && !illegal_o && $stable(bank_active_o)));

  // R3
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] || cmd_o[CMD_ACT_MW]) |->
      (bank_active_o & ~$past(bank_active_o)) != '0);

  // R4
  preall_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_PREALL] |-> bank_active_o == '0);

  // R5
  xfer_needs_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_WR] || cmd_o[CMD_WRA] || cmd_o[CMD_BW] || cmd_o[CMD_BWA] ||
     cmd_o[CMD_RD] || cmd_o[CMD_RDA]) |-> $past(bank_active_o) != '0);

  // R7
  mrs_ref_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_MRS] || cmd_o[CMD_REF]) |-> $past(bank_active_o) == '0);

  // R9
  pdn_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_PDN] || cmd_o[CMD_SREF]) |-> $past(bank_active_o) == '0);

  // R9
  susp_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_CSUSP] |-> $past(bank_active_o) != '0);
endmodule

bind gdram_cmd_decoder gdram_cmd_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cke_prev_i    (cke_prev_i),
  .cmd_o         (cmd_o),
  .illegal_o     (illegal_o),
  .bank_active_o (bank_active_o)
);

// File: tb/sim_gdram_cmd_decoder.sv
module sim_gdram_cmd_decoder;
  import gdram_cmd_pkg::*;

  typedef struct {
    int         cmd;
    bit         ill;
    bit [1:0]   banks;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic dsf = 1'b0, ckp = 1'b1, ck = 1'b1, bank = 1'b0, a8 = 1'b0;
  logic [NUM_CMD-1:0] cmd;
  logic               ill;
  logic [1:0]         banks;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  gdram_cmd_decoder u0 (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .ras_ni (ras_n),
    .cas_ni (cas_n), .we_ni (we_n), .dsf_i (dsf), .cke_prev_i (ckp),
    .cke_i (ck), .bank_i (bank), .a8_i (a8),
    .cmd_o (cmd), .illegal_o (ill), .bank_active_o (banks)
  );

  task automatic vec(input bit c, input bit [2:0] op, input bit d,
                     input bit kp, input bit k, input bit b, input bit a,
                     input int ec, input bit ei, input bit [1:0] eb,
                     input string req);
    exp_t e;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = op; dsf = d;
    ckp = kp; ck = k; bank = b; a8 = a;
    e.cmd = ec; e.ill = ei; e.banks = eb; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares each output cycle against the queued item
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [NUM_CMD-1:0] ev;
      e  = q.pop_front();
      ev = (e.cmd >= 0) ? (NUM_CMD'(1) << e.cmd) : '0;
      n_vec++;
      if (cmd !== ev || ill !== e.ill || banks !== e.banks) begin
        n_bad++;
        $display("FAIL %s: cmd=%h ill=%b banks=%b expected cmd=%h ill=%b banks=%b",
                 e.req, cmd, ill, banks, ev, e.ill, e.banks);
      end
    end
  end

  localparam bit [2:0] NOP = 3'b111, ACT = 3'b011, PRE = 3'b010, WR = 3'b100;
  localparam bit [2:0] RD = 3'b101, MRS = 3'b000, REF = 3'b001, BST = 3'b110;
  localparam int NONE = -1;

  initial begin
    #12000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    n_vec++;
    if (cmd !== '0 || ill !== 1'b0 || banks !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: cmd=%h ill=%b banks=%b expected 0 0 00", cmd, ill, banks);
    end
    rst_n = 1'b1;
    vec(1, NOP, 0, 1, 1, 0, 0, CMD_DESEL,  0, 2'b00, "R2 deselect");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b00, "R2 nop");
    vec(0, BST, 0, 1, 1, 0, 0, NONE,       1, 2'b00, "R8 bst without burst");
    vec(0, ACT, 0, 1, 1, 0, 0, CMD_ACT,    0, 2'b01, "R3 activate b0");
    vec(0, ACT, 0, 1, 1, 0, 0, NONE,       1, 2'b01, "R3 reactivate illegal");
    vec(0, ACT, 1, 1, 1, 1, 0, CMD_ACT_MW, 0, 2'b11, "R3 activate mw b1");
    vec(0, MRS, 0, 1, 1, 0, 0, NONE,       1, 2'b11, "R7 mrs while active");
    vec(0, MRS, 1, 1, 1, 0, 0, CMD_SMRS,   0, 2'b11, "R7 smrs while active");
    vec(0, REF, 0, 1, 1, 0, 0, NONE,       1, 2'b11, "R7 ref while active");
    vec(0, RD,  0, 1, 1, 0, 0, CMD_RD,     0, 2'b11, "R5 read b0");
    vec(0, BST, 0, 1, 1, 0, 0, CMD_BST,    0, 2'b11, "R8 bst in burst");
    vec(0, BST, 0, 1, 1, 0, 0, NONE,       1, 2'b11, "R8 bst after stop");
    vec(0, RD,  1, 1, 1, 0, 0, NONE,       1, 2'b11, "R5 read with dsf");
    vec(0, WR,  0, 1, 1, 1, 1, CMD_WRA,    0, 2'b11, "R5 write ap b1");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b11, "R6 ap edge1");
    vec(0, RD,  0, 1, 1, 0, 0, NONE,       1, 2'b11, "R13 read during ap burst");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b11, "R6 ap edge3");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b01, "R6 ap close b1");
    vec(0, PRE, 0, 1, 1, 0, 0, CMD_PRE,    0, 2'b00, "R4 precharge b0");
    vec(0, PRE, 1, 1, 1, 0, 0, NONE,       1, 2'b00, "R4 precharge dsf");
    vec(0, RD,  0, 1, 1, 0, 0, NONE,       1, 2'b00, "R5 read idle bank");
    vec(0, MRS, 0, 1, 1, 0, 0, CMD_MRS,    0, 2'b00, "R7 mrs idle");
    vec(0, REF, 0, 1, 1, 0, 0, CMD_REF,    0, 2'b00, "R7 refresh idle");
    vec(0, REF, 1, 1, 1, 0, 0, NONE,       1, 2'b00, "R11 refresh opcode dsf");
    vec(0, BST, 1, 1, 1, 0, 0, NONE,       1, 2'b00, "R11 bst opcode dsf");
    vec(0, ACT, 0, 1, 1, 1, 0, CMD_ACT,    0, 2'b10, "R3 activate b1");
    vec(0, WR,  1, 1, 1, 1, 1, CMD_BWA,    0, 2'b10, "R5 block write ap");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b00, "R6 block write closes");
    vec(0, ACT, 0, 1, 1, 0, 0, CMD_ACT,    0, 2'b01, "R3 activate b0");
    vec(0, PRE, 0, 1, 1, 1, 1, CMD_PREALL, 0, 2'b00, "R4 precharge all");
    vec(0, ACT, 0, 1, 1, 0, 0, CMD_ACT,    0, 2'b01, "R3 activate b0");
    vec(0, RD,  0, 1, 1, 0, 1, CMD_RDA,    0, 2'b01, "R5 read ap b0");
    vec(0, NOP, 0, 1, 0, 0, 0, CMD_CSUSP,  0, 2'b01, "R9 clock suspend");
    vec(0, NOP, 0, 0, 0, 0, 0, NONE,       0, 2'b01, "R10 suspended");
    vec(0, ACT, 0, 0, 0, 1, 0, NONE,       0, 2'b01, "R10 act ignored");
    vec(0, NOP, 0, 0, 1, 0, 0, NONE,       0, 2'b01, "R10 exit edge");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b01, "R6 frozen count");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b01, "R6 frozen count");
    vec(0, NOP, 0, 1, 1, 0, 0, CMD_NOP,    0, 2'b00, "R6 close after resume");
    vec(0, ACT, 0, 1, 1, 0, 0, CMD_ACT,    0, 2'b01, "R3 activate b0");
    vec(0, RD,  0, 1, 1, 0, 1, CMD_RDA,    0, 2'b01, "R5 read ap b0");
    vec(0, BST, 0, 1, 1, 0, 0, CMD_BST,    0, 2'b00, "R8 bst closes ap bank");
    vec(1, NOP, 0, 1, 0, 0, 0, CMD_PDN,    0, 2'b00, "R9 power down");
    vec(1, NOP, 0, 0, 1, 0, 0, NONE,       0, 2'b00, "R10 pd exit");
    vec(0, REF, 0, 1, 0, 0, 0, CMD_SREF,   0, 2'b00, "R9 self refresh");
    vec(1, NOP, 0, 0, 1, 0, 0, NONE,       0, 2'b00, "R10 sr exit");
    vec(0, MRS, 0, 1, 0, 0, 0, NONE,       1, 2'b00, "R9 mrs with cke fall");
    vec(0, ACT, 0, 1, 1, 1, 0, CMD_ACT,    0, 2'b10, "R3 activate b1");
    vec(0, WR,  0, 1, 1, 1, 0, CMD_WR,     0, 2'b10, "R5 write b1");
    vec(0, WR,  1, 1, 1, 1, 0, CMD_BW,     0, 2'b10, "R5 block write b1");
    vec(0, PRE, 0, 1, 1, 0, 0, CMD_PRE,    0, 2'b10, "R4 precharge idle b0");
    vec(1, NOP, 0, 1, 1, 0, 0, CMD_DESEL,  0, 2'b10, "R2 deselect keeps state");
    vec(0, PRE, 0, 1, 1, 1, 0, CMD_PRE,    0, 2'b00, "R4 precharge b1");
    vec(1, NOP, 0, 1, 1, 0, 0, CMD_DESEL,  0, 2'b00, "R2 deselect");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule